// File: doc/BRIEF.md
# Fast blank input conditioner

This block takes the asynchronous fast-blank pin of a display processor and turns it into a clean internal fast-blank signal. The pin is brought into the clock domain through a two-flop synchronizer. A mode register selects the source: either the synchronized pin or a level held at active. It also selects whether the signal is active high or active low. The conditioned result drives `fb_o` continuously.

Software sees the block through a simple strobe bus with an 8-bit sub-address. A read-only status byte shows the live synchronized pin level. Beside it sits a sticky flag that records any falling edge of the pin. Reading the status byte returns the flag and clears it in the same access. An edge that arrives during that read is kept for the next read.

Top module: `fblank_if`

## Requirements
- R1: Mode bit 0 picks the source. With 0, the source is the pin after two synchronizing flops, so `fb_o` follows a pin change after the second rising clock edge. With 1, the source is held at logic 1.
- R2: Mode bit 2 sets the polarity. `fb_o` equals the source XOR mode bit 2, so 1 gives an active-low output.
- R3: Status bit 3 holds the synchronized pin level. It is not affected by the mode register.
- R4: Status bit 4 sets on the clock edge after the synchronized pin goes from 1 to 0. It then stays set until the status byte is read.
- R5: A status read returns the current flag value and then clears the flag. If a falling edge is flagged on the same clock edge as the read, the flag stays set.
- R6: Mode bit 1 is stored and reads back. It has no effect on `fb_o` or on the status byte.
- R7: Status bits 7:5 and 2:0 read as zero. Mode bits 7:3 are discarded on write and read as zero.
- R8: Status sits at sub-address 0x40 and mode at 0x41. Read data is registered: it appears on `rdata_o` one cycle after `rd_en_i` and holds until the next read. An unmapped address reads 0, and a write to the status address has no effect.
- R9: After reset the mode register, the flag, the synchronizer and `rdata_o` are all zero, and `fb_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_pin_i | input | 1 | Asynchronous fast-blank pin |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register sub-address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| fb_o | output | 1 | Conditioned internal fast-blank signal |

## Verification
The bench steps the pin low at every offset against a status read. This catches a design that clears the flag after setting it in the same cycle, which would lose the edge. It also catches a flag that sets a cycle too early or too late. Both mode bits are tried in all four combinations and with the pin toggling. A design that forgets to apply polarity to the forced source, or that lets polarity leak into status bit 3, shows a miscompare on `fb_o` or `rdata_o`. The bench also writes all ones to the mode register, writes to the status address and reads an unmapped address, so stray storage or a missing address decode shows up in the read data.

// File: rtl/fblank_pkg.sv
package fblank_pkg;
  localparam int DATA_W        = 8;
  localparam int ADDR_W        = 8;
  localparam int MODE_USED_W   = 3;
  localparam int STAT_LVL_BIT  = 3;
  localparam int STAT_FALL_BIT = 4;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // bit order matches mode register bits 2..0
  typedef struct packed {
    logic pol_low;
    logic clmp_ref;
    logic force_hi;
  } mode_t;
endpackage

// File: rtl/fblank_sync.sv
module fblank_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_comb chain_d[gi] = din;
      end else begin : g_next
        always_comb chain_d[gi] = chain_q[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/fblank_edge.sv
module fblank_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic clr_i,
  output logic flag_o
);
  logic prev_q;
  logic flag_q;
  logic flag_d;
  logic fall;

  always_comb begin
    fall   = prev_q & ~lvl_i;
    // a new edge wins over a clearing read in the same cycle
    flag_d = (flag_q & ~clr_i) | fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/fblank_regs.sv
module fblank_regs
  import fblank_pkg::*;
#(
  parameter addr_t STAT_ADDR = 8'h40,
  parameter addr_t MODE_ADDR = 8'h41
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en_i,
  input  logic  rd_en_i,
  input  addr_t addr_i,
  input  byte_t wdata_i,
  input  logic  lvl_i,
  input  logic  flag_i,
  output mode_t mode_o,
  output logic  stat_rd_o,
  output byte_t rdata_o
);
  mode_t mode_q, mode_d;
  byte_t rdata_q, rdata_d;
  byte_t rd_mux;
  logic  mode_we;
  logic  unused_wbits;

  assign unused_wbits = ^wdata_i[DATA_W-1:MODE_USED_W];

  always_comb begin
    mode_we   = wr_en_i && (addr_i == MODE_ADDR);
    stat_rd_o = rd_en_i && (addr_i == STAT_ADDR);
    mode_d    = mode_we ? mode_t'(wdata_i[MODE_USED_W-1:0]) : mode_q;

    rd_mux = '0;
    if (addr_i == STAT_ADDR) begin
      rd_mux[STAT_LVL_BIT]  = lvl_i;
      rd_mux[STAT_FALL_BIT] = flag_i;
    end else if (addr_i == MODE_ADDR) begin
      rd_mux[MODE_USED_W-1:0] = mode_q;
    end
    rdata_d = rd_en_i ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      rdata_q <= '0;
    end else begin
      mode_q  <= mode_d;
      rdata_q <= rdata_d;
    end
  end

  assign mode_o  = mode_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/fblank_if.sv
module fblank_if
  import fblank_pkg::*;
#(
  parameter addr_t STAT_ADDR   = 8'h40,
  parameter addr_t MODE_ADDR   = 8'h41,
  parameter int    SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fb_pin_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       fb_o
);
  logic  pin_lvl;
  logic  fall_flag;
  logic  stat_rd;
  logic  fb_src;
  mode_t mode;

  fblank_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (fb_pin_i),
    .dout (pin_lvl)
  );

  fblank_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (pin_lvl),
    .clr_i (stat_rd),
    .flag_o(fall_flag)
  );

  fblank_regs #(.STAT_ADDR(STAT_ADDR), .MODE_ADDR(MODE_ADDR)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .lvl_i    (pin_lvl),
    .flag_i   (fall_flag),
    .mode_o   (mode),
    .stat_rd_o(stat_rd),
    .rdata_o  (rdata_o)
  );

  // polarity applies to both sources; clamp-reference bit is not used here
  always_comb begin
    fb_src = mode.force_hi ? 1'b1 : pin_lvl;
    fb_o   = fb_src ^ mode.pol_low;
  end
endmodule

// File: rtl/fblank_if_chk.sv
module fblank_if_chk #(
  parameter logic [7:0] STAT_ADDR = 8'h40,
  parameter logic [7:0] MODE_ADDR = 8'h41
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en_i,
  input logic       rd_en_i,
  input logic [7:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       fb_o
);
  AST_FORCE_ACTIVE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == MODE_ADDR && wdata_i[0] && !wdata_i[2]) |=> fb_o); // R1

  AST_FORCE_ACTIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == MODE_ADDR && wdata_i[0] && wdata_i[2]) |=> !fb_o); // R2

  AST_STAT_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == STAT_ADDR) |=> (rdata_o[7:5] == 3'b0 && rdata_o[2:0] == 3'b0)); // R7

  AST_MODE_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == MODE_ADDR) |=> (rdata_o[7:3] == 5'b0)); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i != MODE_ADDR && addr_i != STAT_ADDR) |=> (rdata_o == 8'h00)); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o)); // R8
endmodule

bind fblank_if fblank_if_chk #(.STAT_ADDR(STAT_ADDR), .MODE_ADDR(MODE_ADDR)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .fb_o   (fb_o)
);

// File: tb/test_fblank_if.sv
`timescale 1ns/1ps
module test_fblank_if;
  localparam logic [7:0] STAT = 8'h40;
  localparam logic [7:0] MODE = 8'h41;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata_o;
  logic       fb_o;

  int    vectors = 0;
  int    errors = 0;
  string tag = "R9";
  bit    done = 1'b0;

  // reference state
  bit       hist[$];
  bit       m_flag;
  bit [2:0] m_mode;
  bit [7:0] m_rdata;

  always #2 clk = ~clk;

  fblank_if i_fblank_if (
    .clk(clk), .rst_n(rst_n), .fb_pin_i(pin), .wr_en_i(wr), .rd_en_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_o), .fb_o(fb_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {1'b0, 1'b0, 1'b0};
      m_flag = 1'b0;
      m_mode = 3'b0;
      m_rdata = 8'h00;
    end else begin
      bit lvl, fall, clr;
      lvl  = hist[1];
      fall = hist[2] && !hist[1];
      clr  = rd && addr == STAT;
      if (rd) begin
        if (addr == STAT)      m_rdata = {3'b0, m_flag, lvl, 3'b0};
        else if (addr == MODE) m_rdata = {5'b0, m_mode};
        else                   m_rdata = 8'h00;
      end
      m_flag = (m_flag && !clr) || fall;
      if (wr && addr == MODE) m_mode = wdata[2:0];
      hist.push_front(pin);
      void'(hist.pop_back());
    end
  end

  function automatic bit exp_fb();
    return (m_mode[0] ? 1'b1 : hist[1]) ^ m_mode[2];
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (rdata_o !== m_rdata) begin
        errors++;
        $display("FAIL %s rdata_o actual %h expected %h at %0t", tag, rdata_o, m_rdata, $time);
      end
      if (fb_o !== exp_fb()) begin
        errors++;
        $display("FAIL %s fb_o actual %b expected %b at %0t", tag, fb_o, exp_fb(), $time);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #0.5;
    wr = 1'b0;
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); #0.5; wr = 1'b0;
  endtask

  task automatic read_reg(input logic [7:0] a);
    addr = a; rd = 1'b1;
    @(negedge clk); #0.5; rd = 1'b0;
  endtask

  initial begin
    #0.5;
    idle(3);
    // R9: reset state at the ports
    vectors++;
    if (rdata_o !== 8'h00 || fb_o !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset rdata_o %h fb_o %b expected 00 0", rdata_o, fb_o);
    end
    rst_n = 1'b1;
    idle(2);

    tag = "R1"; pin = 1'b1; idle(1); pin = 1'b0; idle(1); pin = 1'b1; idle(4);
    tag = "R3"; read_reg(STAT); idle(1);
    tag = "R4"; pin = 1'b0; idle(4); read_reg(STAT); idle(1);
    tag = "R5"; read_reg(STAT); idle(2);

    // R5: falling edge at every offset against a clearing read
    for (int off = 0; off < 6; off++) begin
      tag = "R5";
      pin = 1'b1; idle(4);
      read_reg(STAT);
      pin = 1'b0; idle(off);
      read_reg(STAT); idle(1);
      read_reg(STAT); idle(1);
      read_reg(STAT); idle(1);
    end

    // R2 and R1: all four mode combinations with a toggling pin
    for (int m = 0; m < 8; m++) begin
      tag = (m[0]) ? "R1" : "R2";
      if (m[1]) tag = "R6";
      write_reg(MODE, 8'(m));
      for (int k = 0; k < 6; k++) begin
        pin = k[1];
        idle(1);
      end
      read_reg(MODE); idle(1);
      read_reg(STAT); idle(1);
    end

    tag = "R7"; write_reg(MODE, 8'hFF); read_reg(MODE); idle(2);
    write_reg(MODE, 8'hF8); read_reg(MODE); idle(2);
    tag = "R8"; write_reg(STAT, 8'hFF); read_reg(STAT); idle(1);
    read_reg(8'h00); idle(2); read_reg(8'h42); idle(1);
    pin = 1'b1; idle(3); pin = 1'b0; idle(5);
    read_reg(MODE); idle(3);
    tag = "R6"; write_reg(MODE, 8'h02); pin = 1'b1; idle(3); pin = 1'b0; idle(3);
    read_reg(MODE); idle(2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule